// File: doc/BRIEF.md
# Multichannel Min/Max/Sum Decimation Stage

This block sits in a four-channel acquisition path that also carries a 32-bit logic-analyser word. Every clock it takes four signed 10-bit samples and one 32-bit digital word. It can forward them packed into a 72-bit memory word. It can also reduce them over an interval into four result words: per-channel minimum, per-channel maximum, and two words that each hold a pair of undivided 36-bit running sums. For the digital word, "minimum" means the bitwise AND over the interval and "maximum" means the bitwise OR.

A latch input copies the running results into holding registers on every cycle it is high. A 2-bit selector picks which holding register feeds the registered 72-bit output. A 4-bit lane index picks one byte of that output for a narrow microcontroller port. An enable input gates accumulation. A start-of-interval input makes the next enabled sample load the min and max fields directly and restart the sums.

Top module: `minmax_decimator`

## Requirements
- R1: With `passMode` high, `memWord` equals {digIn at 71:40, channel 3 at 39:30, channel 2 at 29:20, channel 1 at 19:10, channel 0 at 9:0} of the inputs presented two rising edges earlier.
- R2: Each 10-bit field of the minimum word (channel k at bits 10k+9:10k, digital field at 71:40) is replaced by a new enabled sample that is smaller under signed comparison.
- R3: Each 10-bit field of the maximum word (same layout as R2) is replaced by a new enabled sample that is larger under signed comparison.
- R4: The digital field of the minimum word accumulates the bitwise AND of the enabled digital samples in the interval, and the digital field of the maximum word accumulates their bitwise OR.
- R5: The first sum word holds the sign-extended 36-bit running sum of channel 1 in bits 71:36 and that of channel 0 in bits 35:0. The second sum word holds channel 3 (71:36) and channel 2 (35:0). The sums wrap modulo 2^36.
- R6: On each edge where `latchEn` is high, all four running words are copied into the holding registers. While it is low, the holding registers keep their values.
- R7: With `passMode` low, `memWord` is loaded one edge later from the holding register chosen by `viewSel`: 0 selects the minimum word, 1 the maximum word, 2 the first sum word, 3 the second sum word.
- R8: `mcuByte` is `memWord[8k+7:8k]` for `laneIdx` = k in 0..8, and zero for `laneIdx` 9..15.
- R9: An accumulator update is caused by the sample presented with `accEn` high, one edge after that sample's capture edge. Samples presented with `accEn` low leave every running word unchanged.
- R10: The first enabled sample after reset loads the min and max fields directly, and the sums start from it. So does the first enabled sample presented with `startIntvl` high, or following a cycle with `startIntvl` high.
- R11: `rstN` low asynchronously clears all registers, so `memWord` and `mcuByte` read zero at once.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Sample clock |
| rstN | input | 1 | Asynchronous reset, active low |
| chanIn | input | 40 | Four signed 10-bit samples, channel k at bits 10k+9:10k |
| digIn | input | 32 | Digital logic-analyser word |
| passMode | input | 1 | 1: forward packed input; 0: show the selected holding register |
| accEn | input | 1 | Accumulation enable for the sample presented with it |
| startIntvl | input | 1 | Starts a new reduction interval |
| latchEn | input | 1 | Copies the running words into the holding registers |
| viewSel | input | 2 | Holding register select (0 min, 1 max, 2 sum pair 0/1, 3 sum pair 2/3) |
| laneIdx | input | 4 | Byte lane for the microcontroller port |
| memWord | output | 72 | Registered memory word |
| mcuByte | output | 8 | Selected byte of `memWord` |

## Verification
The assertions assume that all control inputs are synchronous to `clk` and change only away from its rising edge. They also assume an interval is short enough that the 36-bit sums mean something; the min-below-max and AND-within-OR relations hold for any sample values. The stimulus changes every input a quarter period after each rising edge and keeps intervals to a few dozen samples. It mixes random values with the signed extremes -512 and +511, so that the signed comparison and the sign extension of the sums are both exercised. Reset is dropped once in the middle of a run, between edges, to confirm the asynchronous clear.

// File: rtl/decim_pkg.sv
package decim_pkg;

  // Holding register codes seen on viewSel
  typedef enum logic [1:0] {
    VIEW_MIN  = 2'd0,
    VIEW_MAX  = 2'd1,
    VIEW_SUMA = 2'd2,
    VIEW_SUMB = 2'd3
  } view_e;

  localparam int VIEW_N = 4;

  // Strobes from the control to the datapath
  typedef struct packed {
    logic loadFirst;   // load min/max directly, restart sums
    logic accumulate;  // compare and add
    logic snap;        // copy running words into holding registers
    logic passThru;    // output forwards packed input
  } strobe_t;

endpackage

// File: rtl/decim_ctrl.sv
module decim_ctrl
  import decim_pkg::*;
(
  input  logic    clk,
  input  logic    rstN,
  input  logic    accEn,
  input  logic    startIntvl,
  input  logic    latchEn,
  input  logic    passMode,
  output strobe_t strb
);

  logic enR;
  logic startR;
  logic fresh;

  // Enable and start travel alongside the sample capture register
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      enR    <= 1'b0;
      startR <= 1'b0;
      fresh  <= 1'b1;
    end else begin
      enR    <= accEn;
      startR <= startIntvl;
      if (enR)         fresh <= 1'b0;
      else if (startR) fresh <= 1'b1;
    end
  end

  always_comb begin
    strb.loadFirst  = enR && (fresh || startR);
    strb.accumulate = enR && !(fresh || startR);
    strb.snap       = latchEn;
    strb.passThru   = passMode;
  end

  // R10: once an enabled sample has been taken, a direct load needs a new start
  assert_reload_needs_start_R10: assert property (@(posedge clk) disable iff (!rstN)
    enR |=> (!strb.loadFirst || startR));

endmodule

// File: rtl/decim_dp.sv
module decim_dp
  import decim_pkg::*;
#(
  parameter int SMP_W  = 10,
  parameter int DIG_W  = 32,
  parameter int SUM_W  = 36,
  parameter int CH_N   = 4,
  parameter int WORD_W = DIG_W + CH_N * SMP_W,
  parameter int LANES  = WORD_W / 8,
  parameter int LANE_W = $clog2(LANES)
) (
  input  logic                          clk,
  input  logic                          rstN,
  input  logic [CH_N-1:0][SMP_W-1:0]    chanIn,
  input  logic [DIG_W-1:0]              digIn,
  input  strobe_t                       strb,
  input  logic [1:0]                    viewSel,
  input  logic [LANE_W-1:0]             laneIdx,
  output logic [WORD_W-1:0]             memWord,
  output logic [7:0]                    mcuByte
);

  localparam int PAIR_W = 2 * SUM_W;
  localparam int PAIRS  = CH_N / 2;

  logic [CH_N-1:0][SMP_W-1:0] chanR;
  logic [DIG_W-1:0]           digR;
  logic [CH_N*SMP_W-1:0]      minAll;
  logic [CH_N*SMP_W-1:0]      maxAll;
  logic [CH_N*SUM_W-1:0]      sumAll;
  logic [DIG_W-1:0]           digAnd;
  logic [DIG_W-1:0]           digOr;
  logic [WORD_W-1:0]          runW  [VIEW_N];
  logic [WORD_W-1:0]          holdW [VIEW_N];

  // Sample capture stage
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      chanR <= '0;
      digR  <= '0;
    end else begin
      chanR <= chanIn;
      digR  <= digIn;
    end
  end

  // Per-channel min, max and running sum
  for (genvar c = 0; c < CH_N; c++) begin : g_ch
    logic signed [SMP_W-1:0] cur;
    logic signed [SMP_W-1:0] minQ;
    logic signed [SMP_W-1:0] maxQ;
    logic        [SUM_W-1:0] sumQ;
    logic        [SUM_W-1:0] curExt;

    assign cur    = chanR[c];
    assign curExt = {{(SUM_W-SMP_W){cur[SMP_W-1]}}, cur};

    always_ff @(posedge clk or negedge rstN) begin
      if (!rstN) begin
        minQ <= '0;
        maxQ <= '0;
        sumQ <= '0;
      end else if (strb.loadFirst) begin
        minQ <= cur;
        maxQ <= cur;
        sumQ <= curExt;
      end else if (strb.accumulate) begin
        if (cur < minQ) minQ <= cur;
        if (cur > maxQ) maxQ <= cur;
        sumQ <= sumQ + curExt;
      end
    end

    assign minAll[c*SMP_W +: SMP_W] = minQ;
    assign maxAll[c*SMP_W +: SMP_W] = maxQ;
    assign sumAll[c*SUM_W +: SUM_W] = sumQ;

    // R2/R3: the running minimum never exceeds the running maximum
    assert_min_not_above_max_R2: assert property (@(posedge clk) disable iff (!rstN)
      minQ <= maxQ);
  end

  // Digital channel: AND for "min", OR for "max"
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      digAnd <= '0;
      digOr  <= '0;
    end else if (strb.loadFirst) begin
      digAnd <= digR;
      digOr  <= digR;
    end else if (strb.accumulate) begin
      digAnd <= digAnd & digR;
      digOr  <= digOr | digR;
    end
  end

  // Running words in output layout
  always_comb begin
    runW[VIEW_MIN] = {digAnd, minAll};
    runW[VIEW_MAX] = {digOr, maxAll};
    for (int p = 0; p < PAIRS; p++) begin
      runW[VIEW_SUMA + p] = WORD_W'(sumAll[p*PAIR_W +: PAIR_W]);
    end
  end

  // Holding registers
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      for (int v = 0; v < VIEW_N; v++) holdW[v] <= '0;
    end else if (strb.snap) begin
      for (int v = 0; v < VIEW_N; v++) holdW[v] <= runW[v];
    end
  end

  // Output register
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN)              memWord <= '0;
    else if (strb.passThru) memWord <= {digR, chanR};
    else                    memWord <= holdW[viewSel];
  end

  // Byte lane pick for the narrow port
  always_comb begin
    mcuByte = '0;
    for (int k = 0; k < LANES; k++) begin
      if (laneIdx == LANE_W'(k)) mcuByte = memWord[k*8 +: 8];
    end
  end

  // R4: AND of the interval is always a subset of its OR
  assert_and_within_or_R4: assert property (@(posedge clk) disable iff (!rstN)
    (digAnd & ~digOr) == '0);

  // R6: without a snap, every holding register keeps its value
  assert_hold_kept_R6: assert property (@(posedge clk) disable iff (!rstN)
    !strb.snap |=> ($stable(holdW[0]) && $stable(holdW[1]) &&
                    $stable(holdW[2]) && $stable(holdW[3])));

  // R9: no update strobe means the digital accumulators do not move
  assert_gated_no_change_R9: assert property (@(posedge clk) disable iff (!rstN)
    !(strb.loadFirst || strb.accumulate) |=> ($stable(digAnd) && $stable(digOr)));

endmodule

// File: rtl/minmax_decimator.sv
module minmax_decimator
  import decim_pkg::*;
#(
  parameter int SMP_W = 10,
  parameter int DIG_W = 32,
  parameter int SUM_W = 36,
  parameter int CH_N  = 4,
  localparam int WORD_W = DIG_W + CH_N * SMP_W,
  localparam int LANES  = WORD_W / 8,
  localparam int LANE_W = $clog2(LANES)
) (
  input  logic                    clk,
  input  logic                    rstN,
  input  logic [CH_N*SMP_W-1:0]   chanIn,
  input  logic [DIG_W-1:0]        digIn,
  input  logic                    passMode,
  input  logic                    accEn,
  input  logic                    startIntvl,
  input  logic                    latchEn,
  input  logic [1:0]              viewSel,
  input  logic [LANE_W-1:0]       laneIdx,
  output logic [WORD_W-1:0]       memWord,
  output logic [7:0]              mcuByte
);

  strobe_t strb;

  decim_ctrl u_ctrl (
    .clk        (clk),
    .rstN       (rstN),
    .accEn      (accEn),
    .startIntvl (startIntvl),
    .latchEn    (latchEn),
    .passMode   (passMode),
    .strb       (strb)
  );

  decim_dp #(
    .SMP_W (SMP_W),
    .DIG_W (DIG_W),
    .SUM_W (SUM_W),
    .CH_N  (CH_N)
  ) u_dp (
    .clk     (clk),
    .rstN    (rstN),
    .chanIn  (chanIn),
    .digIn   (digIn),
    .strb    (strb),
    .viewSel (viewSel),
    .laneIdx (laneIdx),
    .memWord (memWord),
    .mcuByte (mcuByte)
  );

  // Edges since reset, saturating; bounds the look-back of the latency check
  logic [1:0] upCnt;
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN)              upCnt <= '0;
    else if (upCnt != 2'd3) upCnt <= upCnt + 2'd1;
  end

  // R1: forwarded word is the input from two edges back
  assert_pass_latency_R1: assert property (@(posedge clk) disable iff (!rstN)
    (upCnt == 2'd3 && $past(passMode)) |-> memWord == $past({digIn, chanIn}, 2));

  // R8: lane indices past the last byte read zero
  assert_lane_blank_R8: assert property (@(posedge clk) disable iff (!rstN)
    (laneIdx >= LANE_W'(LANES)) |-> mcuByte == 8'd0);

endmodule

// File: tb/sim_minmax_decimator.sv
module sim_minmax_decimator;

  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic [39:0] chanIn = '0;
  logic [31:0] digIn = '0;
  logic        passMode = 1'b0;
  logic        accEn = 1'b0;
  logic        startIntvl = 1'b0;
  logic        latchEn = 1'b0;
  logic [1:0]  viewSel = '0;
  logic [3:0]  laneIdx = '0;
  logic [71:0] memWord;
  logic [7:0]  mcuByte;

  int total = 0;
  int bad = 0;
  bit finished = 1'b0;

  always #10 clk = ~clk;   // 50 MHz

  minmax_decimator u0 (
    .clk(clk), .rstN(rstN), .chanIn(chanIn), .digIn(digIn),
    .passMode(passMode), .accEn(accEn), .startIntvl(startIntvl),
    .latchEn(latchEn), .viewSel(viewSel), .laneIdx(laneIdx),
    .memWord(memWord), .mcuByte(mcuByte)
  );

  // ---------------- reference model ----------------
  int          mIn [4];
  logic [31:0] mDig;
  bit          mEn, mStart, mFresh;
  int          mMin [4];
  int          mMax [4];
  longint      mSum [4];
  logic [31:0] mAnd, mOr;
  logic [71:0] mHold [4];
  logic [71:0] mOut;

  function automatic logic [71:0] runWord(int v);
    logic [71:0] r;
    r = '0;
    case (v)
      0: begin r[71:40] = mAnd; for (int k = 0; k < 4; k++) r[k*10 +: 10] = mMin[k][9:0]; end
      1: begin r[71:40] = mOr;  for (int k = 0; k < 4; k++) r[k*10 +: 10] = mMax[k][9:0]; end
      2: r = {mSum[1][35:0], mSum[0][35:0]};
      default: r = {mSum[3][35:0], mSum[2][35:0]};
    endcase
    return r;
  endfunction

  function automatic logic [71:0] packIn();
    logic [71:0] r;
    r[71:40] = mDig;
    for (int k = 0; k < 4; k++) r[k*10 +: 10] = mIn[k][9:0];
    return r;
  endfunction

  task automatic modelClear();
    for (int k = 0; k < 4; k++) begin
      mIn[k] = 0; mMin[k] = 0; mMax[k] = 0; mSum[k] = 0; mHold[k] = '0;
    end
    mDig = '0; mEn = 0; mStart = 0; mFresh = 1; mAnd = '0; mOr = '0; mOut = '0;
  endtask

  task automatic modelEdge();
    if (!rstN) begin
      modelClear();
      return;
    end
    mOut = passMode ? packIn() : mHold[viewSel];
    if (latchEn) for (int v = 0; v < 4; v++) mHold[v] = runWord(v);
    if (mEn) begin
      if (mFresh || mStart) begin
        for (int k = 0; k < 4; k++) begin mMin[k] = mIn[k]; mMax[k] = mIn[k]; mSum[k] = mIn[k]; end
        mAnd = mDig; mOr = mDig;
      end else begin
        for (int k = 0; k < 4; k++) begin
          if (mIn[k] < mMin[k]) mMin[k] = mIn[k];
          if (mIn[k] > mMax[k]) mMax[k] = mIn[k];
          mSum[k] = mSum[k] + mIn[k];
        end
        mAnd = mAnd & mDig; mOr = mOr | mDig;
      end
    end
    if (mEn) mFresh = 0;
    else if (mStart) mFresh = 1;
    mEn = accEn; mStart = startIntvl;
    for (int k = 0; k < 4; k++) mIn[k] = int'($signed(chanIn[k*10 +: 10]));
    mDig = digIn;
  endtask

  // ---------------- checking ----------------
  task automatic compare(string tag);
    logic [7:0] expB;
    expB = (laneIdx <= 4'd8) ? mOut[laneIdx*8 +: 8] : 8'd0;
    total++;
    if (memWord !== mOut) begin
      bad++;
      $display("FAIL %s memWord actual=%h expected=%h", tag, memWord, mOut);
    end
    total++;
    if (mcuByte !== expB) begin
      bad++;
      $display("FAIL R8 (%s) mcuByte lane=%0d actual=%h expected=%h", tag, laneIdx, mcuByte, expB);
    end
  endtask

  task automatic step(string tag);
    @(posedge clk);
    modelEdge();
    #5;
    compare(tag);
  endtask

  task automatic randInputs(int n);
    for (int k = 0; k < 4; k++) begin
      case ((n + k) % 9)
        0: chanIn[k*10 +: 10] = 10'h200;   // -512
        1: chanIn[k*10 +: 10] = 10'h1FF;   // +511
        default: chanIn[k*10 +: 10] = 10'($urandom_range(0, 1023));
      endcase
    end
    digIn = $urandom;
  endtask

  // ---------------- stimulus ----------------
  initial begin
    modelClear();
    // R11: reset state
    for (int i = 0; i < 3; i++) begin
      randInputs(i);
      step("R11 reset");
    end
    rstN = 1'b1;

    // R1 and R8: pass-through, sweep all lane indices
    passMode = 1'b1;
    for (int i = 0; i < 32; i++) begin
      randInputs(i);
      laneIdx = 4'(i);
      step("R1 pass");
    end

    // R2 R3 R4 R5 R7 R10: fresh interval, latch open, rotate views
    passMode = 1'b0; latchEn = 1'b1; accEn = 1'b1; startIntvl = 1'b1;
    for (int i = 0; i < 40; i++) begin
      randInputs(i);
      viewSel = 2'(i);
      laneIdx = 4'(i % 11);
      step("R2/R3/R4/R5/R7 reduce");
      startIntvl = 1'b0;
    end

    // R9: accumulation gated off
    accEn = 1'b0;
    for (int i = 0; i < 14; i++) begin
      randInputs(i + 3);
      viewSel = 2'(i);
      laneIdx = 4'(i % 9);
      step("R9 gated");
    end

    // R6: latch closed while accumulating
    accEn = 1'b1; latchEn = 1'b0;
    for (int i = 0; i < 14; i++) begin
      randInputs(i + 5);
      viewSel = 2'(i);
      step("R6 hold");
    end
    latchEn = 1'b1;
    for (int i = 0; i < 8; i++) begin
      randInputs(i);
      viewSel = 2'(i);
      step("R6/R7 reopen");
    end

    // R10: start with enable low, then enabled samples reload
    accEn = 1'b0; startIntvl = 1'b1;
    randInputs(2);
    step("R10 start idle");
    startIntvl = 1'b0;
    for (int i = 0; i < 3; i++) begin randInputs(i); step("R10 idle"); end
    accEn = 1'b1;
    for (int i = 0; i < 12; i++) begin
      randInputs(i + 7);
      viewSel = 2'(i);
      step("R10 reload");
    end
    // R10: start together with enable
    startIntvl = 1'b1;
    for (int i = 0; i < 10; i++) begin
      randInputs(i + 1);
      viewSel = 2'(i);
      step("R10 restart");
      startIntvl = 1'b0;
    end

    // R11: asynchronous reset between edges
    laneIdx = 4'd8;
    rstN = 1'b0;
    #2;
    modelClear();
    compare("R11 async");
    step("R11 held");
    rstN = 1'b1;
    passMode = 1'b1;
    for (int i = 0; i < 6; i++) begin
      randInputs(i);
      laneIdx = 4'(i + 9);
      step("R1/R8 after reset");
    end

    finished = 1'b1;
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  // Watchdog
  initial begin
    repeat (20000) @(posedge clk);
    if (!finished) begin
      total++;
      bad++;
      $display("FAIL watchdog expired actual=running expected=done");
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

endmodule